// File: doc/BRIEF.md
# Variable Range Register Encoder

This block turns a region request into the base and mask register words of one variable memory-type range. A request gives a base page number, a size in pages, an 8-bit memory type and the implemented physical address width. An alignment walk runs over several cycles and checks the region. An optional errata mode adds two more rules. The block then returns either the encoded base and mask words, a disable indication when the size is zero, or an error flag. Every result comes with a one-cycle done pulse.

A separate decode path takes a stored mask word pair and returns the region size it describes, one cycle later. When the bits above the mask's highest set bit are not all ones, the path forces them to ones and raises a repair flag before it computes the size. Register words are 64 bits wide and split into a low and a high 32-bit half. High-half bit j stands for address bit j+32. Pages are 4 KiB.

Top module: `vre_encoder`

## Requirements
- R1: After reset, done, err, disabled, dec_done, dec_repaired and dec_free are low and all four register words are zero.
- R2: A request with size zero is accepted whatever the errata mode. It returns disabled=1, err=0 and all four words zero, so the valid bit (mask bit 11) is clear.
- R3: On success, base_lo is the base page number shifted left by 12 with the type in bits 7:0. base_hi holds address bits 63:32 of that value, with every bit at or above phys_bits cleared.
- R4: On success, mask_lo is bits 31:0 of the two's-complement negation of the size, shifted left by 12, with bit 11 (valid) set. mask_hi is bits 63:32 of the same value, with the reserved bits cleared.
- R5: Let last = base + size - 1. While base's bit 0 is 0 and last's bit 0 is 1, both are shifted right by one. A nonzero request fails the alignment check unless the two values end up equal.
- R6: With errata_en=1, a nonzero request whose base has any of page-number bits 9:0 set is rejected (4 MiB alignment).
- R7: With errata_en=1, a nonzero request of type 1 (write-combining) or type 6 (write-back) is rejected when base+size > 0x70000 and base <= 0x7003F (page numbers). Other types are not affected by this rule.
- R8: A rejected request returns err=1, disabled=0 and all four words zero.
- R9: done is high for exactly one cycle. Counting the clock edge that samples req_valid as edge 1, done is seen after edge k+3, where k is the number of shift steps of R5. For size zero it is seen after edge 2.
- R10: req_valid is ignored while a request is in progress. The result then belongs to the first request, and no extra done pulse follows.
- R11: dec_done is high in the cycle after each dec_req cycle. When the valid bit (dec_mask_lo bit 11) is clear, dec_free=1, dec_size=0 and dec_repaired=0.
- R12: On decode, take M = {dec_mask_hi, dec_mask_lo with bits 11:0 cleared}. If M is nonzero and, after setting every bit at or above its highest set bit, it differs from M with the reserved high bits set, then dec_repaired=1 and the filled value is used as the mask.
- R13: dec_size equals the negated effective mask shifted right by 12: the filled mask when nonzero, otherwise M with the reserved bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an encode request (sampled in idle only) |
| req_base | input | PFN_W | Base page number |
| req_size | input | PFN_W | Region size in pages |
| req_type | input | 8 | Memory type code |
| errata_en | input | 1 | Enable the alignment and window errata rules |
| phys_bits | input | 7 | Implemented physical address width |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Request rejected |
| disabled | output | 1 | Range disabled (size zero) |
| base_lo | output | 32 | Base word, low half |
| base_hi | output | 32 | Base word, high half |
| mask_lo | output | 32 | Mask word, low half |
| mask_hi | output | 32 | Mask word, high half |
| dec_req | input | 1 | Decode the given mask |
| dec_mask_lo | input | 32 | Stored mask, low half |
| dec_mask_hi | input | 32 | Stored mask, high half |
| dec_done | output | 1 | Decode result valid |
| dec_size | output | 52 | Decoded size in pages |
| dec_repaired | output | 1 | Mask had to be repaired |
| dec_free | output | 1 | Mask valid bit was clear |

## Verification
Some properties are checked by assertions at every done pulse. A rejected result carries all-zero words. A disabled result carries a clear mask. A good result has its valid bit set and no reserved high bits. The done and dec_done pulses follow their cycle rules. Other behaviour only shows up through bench scenarios, where a reference model supplies the expected values. This covers the exact word values, the alignment outcome and its cycle count, the errata window edges, a second request that arrives while busy, and whether a mask is repaired and what size it decodes to.

// File: rtl/vre_pkg.sv
package vre_pkg;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned REG_W      = 64;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SIZE_W     = REG_W - PAGE_SHIFT;
    localparam int unsigned PBITS_W    = 7;
    localparam logic [WORD_W-1:0] VALID_MASK = 32'h0000_0800;
    localparam logic [7:0] TYPE_WC = 8'd1;
    localparam logic [7:0] TYPE_WB = 8'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ENCODE,
        ST_DONE
    } vre_state_e;

    // high-half bit j is reserved when address bit j+32 lies at or above the width
    function automatic logic [WORD_W-1:0] rsvd_hi_mask(input logic [PBITS_W-1:0] pbits);
        logic [WORD_W-1:0] m;
        for (int j = 0; j < int'(WORD_W); j++) begin
            m[j] = (j + int'(WORD_W)) >= int'(pbits);
        end
        return m;
    endfunction
endpackage

// File: rtl/vre_word_pack.sv
module vre_word_pack
    import vre_pkg::*;
#(
    parameter int unsigned PFN_W = 40
) (
    input  logic [PFN_W-1:0]  base,
    input  logic [PFN_W-1:0]  size,
    input  logic [7:0]        rtype,
    input  logic [WORD_W-1:0] rsvd_hi,
    output logic [WORD_W-1:0] base_lo,
    output logic [WORD_W-1:0] base_hi,
    output logic [WORD_W-1:0] mask_lo,
    output logic [WORD_W-1:0] mask_hi
);
    logic [REG_W-1:0] base_full;
    logic [REG_W-1:0] mask_full;

    always_comb begin
        base_full = (REG_W'(base) << PAGE_SHIFT) | REG_W'(rtype);
        mask_full = (REG_W'(0) - REG_W'(size)) << PAGE_SHIFT;
        base_lo   = base_full[WORD_W-1:0];
        base_hi   = base_full[REG_W-1:WORD_W] & ~rsvd_hi;
        mask_lo   = mask_full[WORD_W-1:0] | VALID_MASK;
        mask_hi   = mask_full[REG_W-1:WORD_W] & ~rsvd_hi;
    end
endmodule

// File: rtl/vre_errata_check.sv
module vre_errata_check
    import vre_pkg::*;
#(
    parameter int unsigned     PFN_W      = 40,
    parameter int unsigned     ALIGN_BITS = 10,
    parameter logic [PFN_W-1:0] WIN_FIRST = 'h70000,
    parameter logic [PFN_W-1:0] WIN_LAST  = 'h7003F
) (
    input  logic             enable,
    input  logic [PFN_W-1:0] base,
    input  logic [PFN_W-1:0] size,
    input  logic [7:0]       rtype,
    output logic             reject
);
    logic [PFN_W:0] end_x;
    logic           misaligned;
    logic           caching_type;
    logic           hits_window;

    always_comb begin
        end_x        = {1'b0, base} + {1'b0, size};
        misaligned   = |base[ALIGN_BITS-1:0];
        caching_type = (rtype == TYPE_WC) || (rtype == TYPE_WB);
        hits_window  = (end_x > {1'b0, WIN_FIRST}) && (base <= WIN_LAST);
        reject       = enable && (misaligned || (caching_type && hits_window));
    end
endmodule

// File: rtl/vre_mask_repair.sv
module vre_mask_repair
    import vre_pkg::*;
(
    input  logic [WORD_W-1:0] mask_lo,
    input  logic [WORD_W-1:0] mask_hi,
    input  logic [WORD_W-1:0] rsvd_hi,
    output logic [SIZE_W-1:0] size,
    output logic              repaired,
    output logic              free
);
    logic [REG_W-1:0] raw;
    logic [REG_W-1:0] with_rsvd;
    logic [REG_W-1:0] fill;
    logic [REG_W-1:0] filled;
    logic [REG_W-1:0] eff;
    logic             upper_seen;
    logic             nonzero;

    always_comb begin
        raw       = {mask_hi, mask_lo & ~32'h0000_0FFF};
        with_rsvd = raw | {rsvd_hi, {WORD_W{1'b0}}};
        nonzero   = |raw;
        // ones at and above the highest set bit of raw
        upper_seen = 1'b0;
        fill       = '0;
        for (int i = int'(REG_W) - 1; i >= 0; i--) begin
            fill[i]    = ~upper_seen;
            upper_seen = upper_seen | raw[i];
        end
        filled = raw | (fill & {REG_W{nonzero}});
        eff    = nonzero ? filled : with_rsvd;
        free   = ~mask_lo[11];
        if (free) begin
            size     = '0;
            repaired = 1'b0;
        end else begin
            size     = SIZE_W'((REG_W'(0) - eff) >> PAGE_SHIFT);
            repaired = nonzero && (filled != with_rsvd);
        end
    end
endmodule

// File: rtl/vre_encoder.sv
module vre_encoder
    import vre_pkg::*;
#(
    parameter int unsigned      PFN_W      = 40,
    parameter int unsigned      ALIGN_BITS = 10,
    parameter logic [PFN_W-1:0] WIN_FIRST  = 'h70000,
    parameter logic [PFN_W-1:0] WIN_LAST   = 'h7003F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PFN_W-1:0]    req_base,
    input  logic [PFN_W-1:0]    req_size,
    input  logic [7:0]          req_type,
    input  logic                errata_en,
    input  logic [PBITS_W-1:0]  phys_bits,
    output logic                done,
    output logic                err,
    output logic                disabled,
    output logic [WORD_W-1:0]   base_lo,
    output logic [WORD_W-1:0]   base_hi,
    output logic [WORD_W-1:0]   mask_lo,
    output logic [WORD_W-1:0]   mask_hi,
    input  logic                dec_req,
    input  logic [WORD_W-1:0]   dec_mask_lo,
    input  logic [WORD_W-1:0]   dec_mask_hi,
    output logic                dec_done,
    output logic [SIZE_W-1:0]   dec_size,
    output logic                dec_repaired,
    output logic                dec_free
);
    localparam logic [PFN_W:0] ONE_X = (PFN_W+1)'(1);

    typedef struct packed {
        vre_state_e        state;
        logic [PFN_W-1:0]  base;
        logic [PFN_W-1:0]  size;
        logic [7:0]        rtype;
        logic [WORD_W-1:0] rsvd;
        logic              errata;
        logic              zero;
        logic              align_ok;
        logic [PFN_W:0]    walk_b;
        logic [PFN_W:0]    walk_l;
        logic [WORD_W-1:0] base_lo;
        logic [WORD_W-1:0] base_hi;
        logic [WORD_W-1:0] mask_lo;
        logic [WORD_W-1:0] mask_hi;
        logic              disabled;
        logic              err;
        logic              dec_done;
        logic [SIZE_W-1:0] dec_size;
        logic              dec_repaired;
        logic              dec_free;
    } vre_regs_t;

    vre_regs_t st_d, st_q;

    logic [WORD_W-1:0] pk_base_lo, pk_base_hi, pk_mask_lo, pk_mask_hi;
    logic              errata_reject;
    logic [SIZE_W-1:0] rp_size;
    logic              rp_repaired;
    logic              rp_free;

    vre_word_pack #(.PFN_W(PFN_W)) u_pack (
        .base    (st_q.base),
        .size    (st_q.size),
        .rtype   (st_q.rtype),
        .rsvd_hi (st_q.rsvd),
        .base_lo (pk_base_lo),
        .base_hi (pk_base_hi),
        .mask_lo (pk_mask_lo),
        .mask_hi (pk_mask_hi)
    );

    vre_errata_check #(
        .PFN_W      (PFN_W),
        .ALIGN_BITS (ALIGN_BITS),
        .WIN_FIRST  (WIN_FIRST),
        .WIN_LAST   (WIN_LAST)
    ) u_errata (
        .enable (st_q.errata),
        .base   (st_q.base),
        .size   (st_q.size),
        .rtype  (st_q.rtype),
        .reject (errata_reject)
    );

    vre_mask_repair u_repair (
        .mask_lo  (dec_mask_lo),
        .mask_hi  (dec_mask_hi),
        .rsvd_hi  (rsvd_hi_mask(phys_bits)),
        .size     (rp_size),
        .repaired (rp_repaired),
        .free     (rp_free)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.base   = req_base;
                    st_d.size   = req_size;
                    st_d.rtype  = req_type;
                    st_d.rsvd   = rsvd_hi_mask(phys_bits);
                    st_d.errata = errata_en;
                    st_d.zero   = (req_size == '0);
                    st_d.walk_b = {1'b0, req_base};
                    st_d.walk_l = {1'b0, req_base} + {1'b0, req_size} - ONE_X;
                    st_d.state  = (req_size == '0) ? ST_ENCODE : ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!st_q.walk_b[0] && st_q.walk_l[0]) begin
                    st_d.walk_b = {1'b0, st_q.walk_b[PFN_W:1]};
                    st_d.walk_l = {1'b0, st_q.walk_l[PFN_W:1]};
                end else begin
                    st_d.align_ok = (st_q.walk_b == st_q.walk_l);
                    st_d.state    = ST_ENCODE;
                end
            end
            ST_ENCODE: begin
                if (st_q.zero) begin
                    st_d.base_lo  = '0;
                    st_d.base_hi  = '0;
                    st_d.mask_lo  = '0;
                    st_d.mask_hi  = '0;
                    st_d.disabled = 1'b1;
                    st_d.err      = 1'b0;
                end else if (!st_q.align_ok || errata_reject) begin
                    st_d.base_lo  = '0;
                    st_d.base_hi  = '0;
                    st_d.mask_lo  = '0;
                    st_d.mask_hi  = '0;
                    st_d.disabled = 1'b0;
                    st_d.err      = 1'b1;
                end else begin
                    st_d.base_lo  = pk_base_lo;
                    st_d.base_hi  = pk_base_hi;
                    st_d.mask_lo  = pk_mask_lo;
                    st_d.mask_hi  = pk_mask_hi;
                    st_d.disabled = 1'b0;
                    st_d.err      = 1'b0;
                end
                st_d.state = ST_DONE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase

        st_d.dec_done = dec_req;
        if (dec_req) begin
            st_d.dec_size     = rp_size;
            st_d.dec_repaired = rp_repaired;
            st_d.dec_free     = rp_free;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done         = (st_q.state == ST_DONE);
    assign err          = st_q.err && done;
    assign disabled     = st_q.disabled && done;
    assign base_lo      = st_q.base_lo;
    assign base_hi      = st_q.base_hi;
    assign mask_lo      = st_q.mask_lo;
    assign mask_hi      = st_q.mask_hi;
    assign dec_done     = st_q.dec_done;
    assign dec_size     = st_q.dec_size;
    assign dec_repaired = st_q.dec_repaired;
    assign dec_free     = st_q.dec_free;
endmodule

// File: rtl/vre_encoder_checker.sv
module vre_encoder_checker
    import vre_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [PBITS_W-1:0]  phys_bits,
    input logic                done,
    input logic                err,
    input logic                disabled,
    input logic [WORD_W-1:0]   base_lo,
    input logic [WORD_W-1:0]   base_hi,
    input logic [WORD_W-1:0]   mask_lo,
    input logic [WORD_W-1:0]   mask_hi,
    input logic                dec_req,
    input logic                dec_done,
    input logic [SIZE_W-1:0]   dec_size,
    input logic                dec_repaired,
    input logic                dec_free
);
    AST_DISABLE_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        done && disabled |-> mask_lo == '0 && mask_hi == '0 && !err); // R2
    AST_RSVD_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> ((base_hi | mask_hi) & rsvd_hi_mask(phys_bits)) == '0); // R3
    AST_VALID_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && !disabled |-> mask_lo[11]); // R4
    AST_REJECT_ZERO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> base_lo == '0 && base_hi == '0 && mask_lo == '0 && mask_hi == '0 && !disabled); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |=> dec_done); // R11
    AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_req |=> !dec_done); // R11
    AST_DEC_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done && dec_free |-> dec_size == '0 && !dec_repaired); // R11
endmodule

bind vre_encoder vre_encoder_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phys_bits    (phys_bits),
    .done         (done),
    .err          (err),
    .disabled     (disabled),
    .base_lo      (base_lo),
    .base_hi      (base_hi),
    .mask_lo      (mask_lo),
    .mask_hi      (mask_hi),
    .dec_req      (dec_req),
    .dec_done     (dec_done),
    .dec_size     (dec_size),
    .dec_repaired (dec_repaired),
    .dec_free     (dec_free)
);

// File: tb/vre_encoder_test.sv
module vre_encoder_test;
    localparam int PW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_base = '0;
    logic [PW-1:0] req_size = '0;
    logic [7:0]    req_type = '0;
    logic          errata_en = 1'b0;
    logic [6:0]    phys_bits = 7'd36;
    logic          done, err, disabled;
    logic [31:0]   base_lo, base_hi, mask_lo, mask_hi;
    logic          dec_req = 1'b0;
    logic [31:0]   dec_mask_lo = '0;
    logic [31:0]   dec_mask_hi = '0;
    logic          dec_done, dec_repaired, dec_free;
    logic [51:0]   dec_size;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vre_encoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_size(req_size), .req_type(req_type), .errata_en(errata_en),
        .phys_bits(phys_bits), .done(done), .err(err), .disabled(disabled),
        .base_lo(base_lo), .base_hi(base_hi), .mask_lo(mask_lo), .mask_hi(mask_hi),
        .dec_req(dec_req), .dec_mask_lo(dec_mask_lo), .dec_mask_hi(dec_mask_hi),
        .dec_done(dec_done), .dec_size(dec_size), .dec_repaired(dec_repaired),
        .dec_free(dec_free)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rsv(input logic [6:0] pb);
        logic [31:0] m;
        for (int j = 0; j < 32; j++) m[j] = (j + 32) >= int'(pb);
        return m;
    endfunction

    function automatic void walk(input logic [PW-1:0] b, input logic [PW-1:0] s,
                                 output int k, output bit ok);
        logic [PW:0] x, y;
        x = {1'b0, b};
        y = {1'b0, b} + {1'b0, s} - 41'd1;
        k = 0;
        while (!x[0] && y[0]) begin
            x = x >> 1;
            y = y >> 1;
            k++;
        end
        ok = (x == y);
    endfunction

    function automatic void dec_model(input logic [31:0] lo, input logic [31:0] hi, input logic [6:0] pb,
                                      output logic [51:0] sz, output bit rep, output bit fr);
        logic [63:0] raw, full, fx, eff;
        int msb;
        raw  = {hi, lo & 32'hFFFF_F000};
        full = raw | {rsv(pb), 32'd0};
        fr   = !lo[11];
        rep  = 0;
        sz   = '0;
        if (!fr) begin
            eff = full;
            if (raw != 0) begin
                msb = 0;
                for (int i = 0; i < 64; i++) if (raw[i]) msb = i;
                fx  = raw | ~((64'd1 << msb) - 64'd1);
                rep = (fx != full);
                eff = fx;
            end
            sz = 52'((64'd0 - eff) >> 12);
        end
    endfunction

    task automatic run_req(input logic [PW-1:0] b, input logic [PW-1:0] s, input logic [7:0] t,
                           input logic e, input logic [6:0] pb, input bit inject);
        int n, k, lat;
        bit aok, win, mis, rej, zero;
        logic [63:0] bf, mf;
        logic [31:0] eb_lo, eb_hi, em_lo, em_hi;
        string etag;
        @(negedge clk);
        req_valid = 1; req_base = b; req_size = s; req_type = t; errata_en = e; phys_bits = pb;
        n = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1 && inject) begin
                req_base = ~b; req_size = 40'd1; req_type = 8'd0;
            end else begin
                req_valid = 0;
            end
            if (done || n > 100) break;
        end
        zero = (s == 0);
        walk(b, s, k, aok);
        mis = e && (b[9:0] != 0);
        win = e && (t == 8'd1 || t == 8'd6) &&
              (({1'b0, b} + {1'b0, s}) > 41'h70000) && (b <= 40'h7003F);
        rej = !zero && (!aok || mis || win);
        lat = zero ? 2 : k + 3;
        chk(done && n == lat, "R9 latency", 64'(n), 64'(lat));
        chk(disabled == zero, "R2 disabled", 64'(disabled), 64'(zero));
        etag = zero ? "R2 err" : !aok ? "R5 err" : mis ? "R6 err" : win ? "R7 err" : "R5 ok";
        chk(err == rej, etag, 64'(err), 64'(rej));
        bf = ({24'd0, b} << 12) | 64'(t);
        mf = (64'd0 - {24'd0, s}) << 12;
        if (zero || rej) begin
            eb_lo = 0; eb_hi = 0; em_lo = 0; em_hi = 0;
        end else begin
            eb_lo = bf[31:0]; eb_hi = bf[63:32] & ~rsv(pb);
            em_lo = mf[31:0] | 32'h800; em_hi = mf[63:32] & ~rsv(pb);
        end
        chk({base_hi, base_lo} == {eb_hi, eb_lo}, rej ? "R8 base" : zero ? "R2 base" : "R3 base",
            {base_hi, base_lo}, {eb_hi, eb_lo});
        chk({mask_hi, mask_lo} == {em_hi, em_lo}, rej ? "R8 mask" : zero ? "R2 mask" : "R4 mask",
            {mask_hi, mask_lo}, {em_hi, em_lo});
        if (inject) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!done, "R10 no second done", 64'(done), 64'd0);
            end
        end
    endtask

    task automatic run_dec(input logic [31:0] lo, input logic [31:0] hi, input logic [6:0] pb);
        logic [51:0] sz;
        bit rep, fr;
        @(negedge clk);
        dec_req = 1; dec_mask_lo = lo; dec_mask_hi = hi; phys_bits = pb;
        @(posedge clk);
        @(negedge clk);
        dec_req = 0;
        dec_model(lo, hi, pb, sz, rep, fr);
        chk(dec_done, "R11 dec_done", 64'(dec_done), 64'd1);
        chk(dec_free == fr, "R11 free", 64'(dec_free), 64'(fr));
        chk(dec_repaired == rep, "R12 repaired", 64'(dec_repaired), 64'(rep));
        chk(dec_size == sz, "R13 size", 64'(dec_size), 64'(sz));
        @(posedge clk);
        @(negedge clk);
        chk(!dec_done, "R11 dec_done drop", 64'(dec_done), 64'd0);
    endtask

    function automatic logic [PW-1:0] rnd40();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[PW-1:0];
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !err && !disabled && !dec_done && !dec_repaired && !dec_free,
            "R1 flags", {58'd0, done, err, disabled, dec_done, dec_repaired, dec_free}, 64'd0);
        chk({base_lo, base_hi, mask_lo, mask_hi} == '0, "R1 words", {base_lo, mask_lo}, 64'd0);
        rst_n = 1;

        // directed corners
        run_req(40'h12345, 40'd0, 8'd6, 1'b1, 7'd36, 0);          // R2 zero size under errata
        run_req(40'h0, 40'd1, 8'd6, 1'b0, 7'd36, 0);              // R3 R4 single page
        run_req(40'h100, 40'h100, 8'd0, 1'b0, 7'd40, 0);          // R5 aligned power of two
        run_req(40'h100, 40'h80, 8'd0, 1'b0, 7'd40, 0);           // R5 size smaller than alignment
        run_req(40'h2, 40'd4, 8'd0, 1'b0, 7'd40, 0);              // R5 misaligned
        run_req(40'h0, 40'd3, 8'd0, 1'b0, 7'd40, 0);              // R5 not power of two
        run_req(40'h200, 40'h200, 8'd0, 1'b1, 7'd40, 0);          // R6 not 4 MiB aligned
        run_req(40'h400, 40'h400, 8'd0, 1'b1, 7'd40, 0);          // R6 4 MiB aligned accepted
        run_req(40'h6FC00, 40'h400, 8'd1, 1'b1, 7'd40, 0);        // R7 ends at window start, ok
        run_req(40'h6F800, 40'h800, 8'd1, 1'b1, 7'd40, 0);        // R7 ends at window start, ok
        run_req(40'h70000, 40'h400, 8'd6, 1'b1, 7'd40, 0);        // R7 WB in window rejected
        run_req(40'h70000, 40'h400, 8'd0, 1'b1, 7'd40, 0);        // R7 UC in window allowed
        run_req(40'h70000, 40'h400, 8'd6, 1'b0, 7'd40, 0);        // R7 errata off allowed
        run_req(40'h60000, 40'h20000, 8'd1, 1'b1, 7'd40, 0);      // R7 spans window
        run_req(40'h80_0000_0000 >> 1, 40'h40_0000_0000, 8'd6, 1'b0, 7'd52, 0); // R3 R4 wide
        run_req(40'hFF_FFFF_F000, 40'h1000, 8'd4, 1'b0, 7'd36, 0); // R3 R4 reserved clearing
        run_req(40'h1000, 40'h1000, 8'd6, 1'b0, 7'd40, 1);        // R10 request while busy

        // random requests
        for (int i = 0; i < 300; i++) begin
            logic [PW-1:0] b, s;
            logic [7:0] t;
            int r, sh;
            r  = int'($urandom_range(0, 4));
            sh = int'($urandom_range(0, 30));
            t  = 8'($urandom_range(0, 7));
            b  = rnd40();
            s  = 40'd1 << sh;
            case (r)
                0: b = b & ~(s - 40'd1);
                1: s = rnd40() >> $urandom_range(0, 39);
                2: begin b = 40'h70000 + 40'($urandom_range(0, 64)) - 40'd32; s = 40'($urandom_range(1, 64)); end
                3: s = 0;
                default: begin b = b & ~(s - 40'd1); t = 8'd6; end
            endcase
            run_req(b, s, t, 1'($urandom_range(0, 1)), 7'($urandom_range(36, 52)), i % 25 == 0 && s != 0);
        end

        // decode directed
        run_dec(32'h0000_0000, 32'h0000_000F, 7'd36);   // R11 free
        run_dec(32'hFFF0_0800, 32'h0000_000F, 7'd36);   // R13 proper mask
        run_dec(32'h0000_0800, 32'h0000_0005, 7'd36);   // R12 hole below top
        run_dec(32'h0000_0800, 32'h0000_0000, 7'd36);   // R13 empty mask, reserved only
        run_dec(32'hF000_0800, 32'h0000_0000, 7'd40);   // R12 upper bits missing
        for (int i = 0; i < 60; i++) begin
            run_dec($urandom(), $urandom(), 7'($urandom_range(36, 52)));
        end
        summary();
    end
endmodule